// File: doc/BRIEF.md
# Serial Two-Ones Detector

This block decides whether a wide data word holds more than one set bit. It uses no wide adder or comparison tree. A start strobe loads the word into a shift register, and the register then moves one bit per clock toward its least significant end. The control logic watches the bit that leaves the register. It records the first set bit it sees and stops at the second.

Two set bits are appended above the data word. These padding bits guarantee that a second one always turns up, so the scan needs no position counter to end. A companion tag register shifts in step with the data and marks which positions are padding. When the second one is found, the result is asserted only if that one came from the data region.

A scan lasts at most DATA_W+2 cycles. Only one word is processed per scan. A start received while a scan is running is ignored. At the end of each scan, done pulses for one cycle and the result flag is updated. The result flag then holds its value until the next accepted start.

Top module: `ser_two_ones`

## Requirements
- R1: While reset is asserted, and after it is released, done_o and multi_o are 0.
- R2: When start_i is sampled high and no scan is running, data_i is captured and a scan begins. Bit 0 is examined first, one bit per clock edge, in increasing bit order.
- R3: If data_i has two or more set bits, let p be the index of the second-lowest set bit. done_o is high in the cycle after the (p+1)-th clock edge following the start edge, with multi_o = 1.
- R4: If data_i has exactly one set bit, done_o is high after DATA_W+1 edges, with multi_o = 0.
- R5: If data_i is all zeros, done_o is high after DATA_W+2 edges, with multi_o = 0.
- R6: done_o is high for exactly one cycle per scan.
- R7: multi_o is cleared by an accepted start. It is then constant until the next done pulse, and after that it holds until the next accepted start.
- R8: A start_i pulse during a scan, carrying any data, changes neither the result nor the cycle in which done_o arrives.
- R9: No scan runs longer than DATA_W+2 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load strobe; ignored while a scan is running |
| data_i | input | DATA_W | Word to test, sampled with an accepted start |
| done_o | output | 1 | One-cycle pulse at the end of a scan |
| multi_o | output | 1 | 1 when the last scanned word held two or more set bits |

## Verification
The bench holds start_i high for one edge and then counts the edges until done_o is seen. Its model predicts the count as p+1, where p is the position of the second set bit. For words with one set bit or none, p falls into the padding, at DATA_W or DATA_W+1. All outputs are sampled on the falling edge, so every register stage has settled before a value is read. The bench checks that done_o is low on the falling edge after the pulse, and that multi_o is cleared on the first falling edge after the start and stays unchanged while the block is idle. Some scans receive an extra start, carrying inverted data, on their second edge; for these, the expected edge count and result are unchanged.

// File: rtl/ser_pkg.sv
package ser_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;

  localparam int unsigned PAD_BITS = 2;
endpackage

// File: rtl/ser_shift_lane.sv
module ser_shift_lane #(
  parameter int unsigned WIDTH = 514
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             shift_i,
  output logic             lsb_o
);
  logic [WIDTH-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= load_val_i;
    else if (shift_i) sr_q <= {1'b0, sr_q[WIDTH-1:1]};
  end

  assign lsb_o = sr_q[0];
endmodule

// File: rtl/ser_scan_ctrl.sv
module ser_scan_ctrl
  import ser_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic bit_i,
  input  logic pad_i,
  output logic load_o,
  output logic shift_o,
  output logic busy_o,
  output logic done_o,
  output logic multi_o
);
  scan_state_e state_q;
  logic        seen_q;
  logic        done_q;
  logic        multi_q;

  assign load_o  = start_i && (state_q == ST_IDLE);
  assign shift_o = (state_q == ST_SCAN);
  assign busy_o  = (state_q == ST_SCAN);
  assign done_o  = done_q;
  assign multi_o = multi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      seen_q  <= 1'b0;
      done_q  <= 1'b0;
      multi_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_SCAN;
            seen_q  <= 1'b0;
            multi_q <= 1'b0;
          end
        end
        ST_SCAN: begin
          if (bit_i) begin
            if (seen_q) begin
              // second one ends the scan; padding ones never count
              done_q  <= 1'b1;
              multi_q <= ~pad_i;
              state_q <= ST_IDLE;
            end else begin
              seen_q <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_hold_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(multi_o));

  p_pad_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && seen_q && bit_i && pad_i) |=> (done_o && !multi_o));

  p_busy_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !(bit_i && seen_q)) |=> busy_o);
endmodule

// File: rtl/ser_two_ones.sv
module ser_two_ones
  import ser_pkg::*;
#(
  parameter int unsigned DATA_W = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              done_o,
  output logic              multi_o
);
  localparam int unsigned SR_W  = DATA_W + PAD_BITS;
  localparam int unsigned CNT_W = $clog2(SR_W + 2);

  logic            load;
  logic            shift;
  logic            busy;
  logic [SR_W-1:0] lane_val [2];
  logic            lane_lsb [2];

  // lane 0: data with padding ones on top; lane 1: tag marking the padding
  assign lane_val[0] = {{PAD_BITS{1'b1}}, data_i};
  assign lane_val[1] = {{PAD_BITS{1'b1}}, {DATA_W{1'b0}}};

  for (genvar g = 0; g < 2; g++) begin : g_lane
    ser_shift_lane #(.WIDTH(SR_W)) lane_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load),
      .load_val_i (lane_val[g]),
      .shift_i    (shift),
      .lsb_o      (lane_lsb[g])
    );
  end

  ser_scan_ctrl ctrl_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .bit_i   (lane_lsb[0]),
    .pad_i   (lane_lsb[1]),
    .load_o  (load),
    .shift_o (shift),
    .busy_o  (busy),
    .done_o  (done_o),
    .multi_o (multi_o)
  );

  // scan length monitor, used only by the assertion below
  logic [CNT_W-1:0] scan_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   scan_cnt_q <= '0;
    else if (load) scan_cnt_q <= '0;
    else if (busy) scan_cnt_q <= scan_cnt_q + 1'b1;
  end

  p_scan_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (scan_cnt_q < CNT_W'(SR_W)));

  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> (!done_o && !multi_o));
endmodule

// File: tb/ser_two_ones_tb_top.sv
module ser_two_ones_tb_top;
  localparam int unsigned W = 512;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] data = '0;
  logic         done;
  logic         multi;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #2.5 clk = ~clk;

  ser_two_ones #(.DATA_W(W)) dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start),
    .data_i  (data),
    .done_o  (done),
    .multi_o (multi)
  );

  function automatic int second_pos(logic [W-1:0] d);
    int c = 0;
    for (int i = 0; i < W; i++) begin
      if (d[i]) begin
        c++;
        if (c == 2) return i;
      end
    end
    return (c == 1) ? W : W + 1;
  endfunction

  function automatic logic [W-1:0] k_bits(int k);
    logic [W-1:0] d = '0;
    for (int i = 0; i < k; i++) d[$urandom_range(W-1, 0)] = 1'b1;
    return d;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic run_scan(logic [W-1:0] d, bit inject);
    int  p     = second_pos(d);
    int  edges = 0;
    bit  exp_m = (p < W);
    string req = (p < W) ? "R3" : ((p == W) ? "R4" : "R5");
    @(negedge clk);
    start = 1'b1;
    data  = d;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    data  = ~d;
    check("R7 clear on start", int'(multi), 0);
    while (edges < W + 8) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (inject && edges == 1) begin
        start = 1'b1;  // R8: start during scan must be ignored
        data  = ~d;
      end else begin
        start = 1'b0;
      end
      if (done) break;
    end
    start = 1'b0;
    check({req, " done edge"}, edges, p + 1);
    check({req, " result"}, int'(multi), int'(exp_m));
    if (inject) check("R8 injected start", int'(multi), int'(exp_m));
    @(negedge clk);
    check("R6 single pulse", int'(done), 0);
    check("R9 bound", int'(edges <= W + 2), 1);
    repeat (2) @(negedge clk);
    check("R7 hold idle", int'(multi), int'(exp_m));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 done reset", int'(done), 0);
    check("R1 multi reset", int'(multi), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after release", int'(done), 0);

    // directed corners
    run_scan('0, 1'b0);                            // R5 zero
    d = '0; d[0] = 1'b1;          run_scan(d, 1'b0); // R4 single low
    d = '0; d[W-1] = 1'b1;        run_scan(d, 1'b0); // R4 single top
    d = '0; d[0] = 1'b1; d[1] = 1'b1; run_scan(d, 1'b0); // R2 LSB first
    d = '0; d[W-2] = 1'b1; d[W-1] = 1'b1; run_scan(d, 1'b1); // R3 last positions
    run_scan('1, 1'b0);                            // R3 all ones
    d = '0; d[5] = 1'b1; d[W-1] = 1'b1; run_scan(d, 1'b1);
    run_scan('0, 1'b1);                            // R8 on empty word

    // random words with 0..4 and many set bits
    for (int t = 0; t < 60; t++) begin
      int k = (t % 6 == 5) ? int'($urandom_range(40, 8)) : (t % 5);
      run_scan(k_bits(k), (t % 3 == 0));
    end

    // random low-density positions near the top
    for (int t = 0; t < 10; t++) begin
      d = '0;
      d[W - 1 - $urandom_range(3, 0)] = 1'b1;
      d[W - 1 - $urandom_range(3, 0)] = 1'b1;
      run_scan(d, 1'b1);
    end

    finish_run();
  end
endmodule